// File: doc/BRIEF.md
# Manchester Line Codec with Edge-Gated Receiver

This block converts parallel words to and from a two-level Manchester line for the baseband link between a tag reader and its transponders. The transmitter takes a word and a code length, sends a one-half-bit high sync pulse, and then sends each data bit, most significant first, as two half-bit symbols. The receiver is armed by a single pulse. It ignores the line until a rising edge marks the sync pulse, then samples each half-symbol near its centre and rebuilds the word.

Both directions are timed by loadable down-counters. The reload value is the half-bit width in clock cycles, given as two bytes. The receiver realigns its timer on every mid-bit transition, so a sender whose bit rate drifts slightly is still decoded. A symbol pair with no transition in the middle is reported as a coding fault and ends the frame.

Top module: `manchester_codec`

## Requirements
- R1: After reset, line_out, tx_busy, tx_done, rx_busy, rx_valid and code_error are all low.
- R2: In the cycle after tx_start is accepted, line_out goes high for H cycles (the sync half). Then, for each bit from tx_data[L-1] down to tx_data[0], line_out carries the bit value for H cycles and its inverse for H cycles, so a 1 is sent as 10 and a 0 as 01. H = half_hi*256 + half_lo, and H >= 2.
- R3: tx_done is high for exactly one cycle, H + 2*L*H + 1 cycles after the clock edge that accepted tx_start. In that cycle and whenever the transmitter is idle, line_out is low.
- R4: Once armed by rx_arm, the receiver produces neither rx_valid nor code_error and stays busy until a rising edge appears on line_in.
- R5: A received pair 10 decodes to 1 and a pair 01 decodes to 0. When L bits have been taken, rx_valid pulses for one cycle and rx_data holds them right-justified, with the first-received bit at rx_data[L-1] and all higher bits zero.
- R6: Code lengths of 1 and 64 bits are both sent and received correctly.
- R7: A received pair 00 or 11 gives a one-cycle code_error pulse and ends the frame: no rx_valid follows, and rx_busy drops.
- R8: The receiver realigns on each mid-bit transition, so it decodes a 16-bit frame correctly when the sender's half-bit width is H-1 or H+1 cycles.
- R9: The half-bit width is composed from both bytes, so a value above 255 (half_hi=1, half_lo=1) times the line correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_lo | input | 8 | Low byte of the half-bit width in cycles |
| half_hi | input | 8 | High byte of the half-bit width in cycles |
| code_len | input | 7 | Bits per frame, 1 to 64 |
| tx_start | input | 1 | Starts a transmission when the transmitter is idle |
| tx_data | input | 64 | Word to send; bits [code_len-1:0] are used |
| line_out | output | 1 | Encoded line, low when idle |
| tx_busy | output | 1 | Transmitter is sending |
| tx_done | output | 1 | One-cycle pulse after the last half-symbol |
| rx_arm | input | 1 | Arms the receiver when it is idle |
| line_in | input | 1 | Encoded line from the far end |
| rx_data | output | 64 | Decoded word, right-justified |
| rx_valid | output | 1 | One-cycle pulse when a full frame is decoded |
| code_error | output | 1 | One-cycle pulse on an invalid symbol pair |
| rx_busy | output | 1 | Receiver is armed or decoding |

## Verification
The assertions assume that half_lo, half_hi and code_len stay fixed while a frame is in flight, that H is at least 2, and that code_len lies between 1 and 64. The stimulus changes these only while both sides are idle. Random trials draw H from 2 to 6 and lengths from 1 to 64, and directed cases cover the limits of each range. Line waveforms that the bench drives directly keep every half-symbol within one cycle of H, which is the drift the realignment is meant to absorb.

// File: rtl/mcodec_pkg.sv
package mcodec_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned HALF_W = 2 * BYTE_W;

    typedef enum logic [1:0] {TX_IDLE, TX_SYNC, TX_DATA, TX_DONE} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_HUNT, RX_FIRST, RX_SECOND} rx_state_e;

    typedef struct packed {
        logic first;
        logic second;
    } half_pair_t;

    // a legal symbol pair always changes level in mid-bit
    function automatic logic pair_legal(half_pair_t p);
        return p.first ^ p.second;
    endfunction

    function automatic logic [HALF_W-1:0] join_bytes(logic [BYTE_W-1:0] hi, logic [BYTE_W-1:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/mc_half_timer.sv
module mc_half_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);

    // R2: the timer steps down by one per cycle unless reloaded
    a_r2_timer_step: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

endmodule

// File: rtl/mc_tx.sv
module mc_tx
    import mcodec_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LEN_W  = $clog2(DATA_W + 1),
    parameter int unsigned TW     = HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  len,
    input  logic [TW-1:0]     half_w,
    output logic              line,
    output logic              busy,
    output logic              done
);
    tx_state_e         st;
    logic [DATA_W-1:0] sh;
    logic [LEN_W-1:0]  left;
    logic              half;
    logic              tm_load;
    logic              tm_zero;

    mc_half_timer #(.W(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tm_load),
        .load_val(half_w - TW'(1)), .expired(tm_zero)
    );

    always_comb begin
        unique case (st)
            TX_IDLE: tm_load = start;
            TX_SYNC: tm_load = tm_zero;
            TX_DATA: tm_load = tm_zero && !(half && left == LEN_W'(1));
            default: tm_load = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= TX_IDLE;
            sh   <= '0;
            left <= '0;
            half <= 1'b0;
        end else begin
            unique case (st)
                TX_IDLE: if (start) begin
                    sh   <= data << (LEN_W'(DATA_W) - len);
                    left <= len;
                    st   <= TX_SYNC;
                end
                TX_SYNC: if (tm_zero) begin
                    half <= 1'b0;
                    st   <= TX_DATA;
                end
                TX_DATA: if (tm_zero) begin
                    if (!half)                   half <= 1'b1;
                    else if (left == LEN_W'(1))  st   <= TX_DONE;
                    else begin
                        left <= left - LEN_W'(1);
                        sh   <= sh << 1;
                        half <= 1'b0;
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (st)
            TX_SYNC: line = 1'b1;
            TX_DATA: line = half ? ~sh[DATA_W-1] : sh[DATA_W-1];
            default: line = 1'b0;
        endcase
    end

    assign busy = (st != TX_IDLE);
    assign done = (st == TX_DONE);

    a_r2_sync_first: assert property (@(posedge clk) disable iff (rst)
        (st == TX_IDLE && start) |=> (line && st == TX_SYNC));

    a_r2_half_stable: assert property (@(posedge clk) disable iff (rst)
        (st == TX_DATA && !tm_zero) |=> $stable(line));

    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !line));

endmodule

// File: rtl/mc_rx.sv
module mc_rx
    import mcodec_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LEN_W  = $clog2(DATA_W + 1),
    parameter int unsigned TW     = HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic [LEN_W-1:0]  len,
    input  logic [TW-1:0]     half_w,
    input  logic              line_in,
    output logic [DATA_W-1:0] data,
    output logic              valid,
    output logic              err,
    output logic              busy
);
    localparam int unsigned CW = TW + 1;

    rx_state_e        st;
    logic             s1, s2;
    logic             rise, toggle;
    logic             first_q, realigned;
    logic [LEN_W-1:0] left;
    half_pair_t       pair;
    logic             tm_load, tm_zero;
    logic [CW-1:0]    tm_val;
    logic [CW-1:0]    full_val, mid_val, lead_val;

    assign full_val = CW'(half_w) - CW'(1);
    assign mid_val  = CW'(half_w >> 1) - CW'(1);
    assign lead_val = CW'(half_w) + CW'(half_w >> 1) - CW'(1);

    assign rise   = s1 & ~s2;
    assign toggle = s1 ^ s2;
    assign pair   = '{first: first_q, second: s1};

    mc_half_timer #(.W(CW)) u_timer (
        .clk(clk), .rst(rst), .load(tm_load),
        .load_val(tm_val), .expired(tm_zero)
    );

    always_comb begin
        tm_load = 1'b0;
        tm_val  = full_val;
        unique case (st)
            RX_HUNT:  if (rise) begin tm_load = 1'b1; tm_val = lead_val; end
            RX_FIRST: tm_load = tm_zero;
            RX_SECOND: begin
                if (toggle && !realigned) begin
                    tm_load = 1'b1;
                    tm_val  = mid_val;
                end else if (tm_zero && pair_legal(pair) && left != LEN_W'(1)) begin
                    tm_load = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RX_IDLE;
            s1        <= 1'b0;
            s2        <= 1'b0;
            first_q   <= 1'b0;
            realigned <= 1'b0;
            left      <= '0;
            data      <= '0;
            valid     <= 1'b0;
            err       <= 1'b0;
        end else begin
            s1    <= line_in;
            s2    <= s1;
            valid <= 1'b0;
            err   <= 1'b0;
            unique case (st)
                RX_IDLE: if (arm) begin
                    left <= len;
                    data <= '0;
                    st   <= RX_HUNT;
                end
                RX_HUNT: if (rise) st <= RX_FIRST;
                RX_FIRST: if (tm_zero) begin
                    first_q   <= s1;
                    realigned <= 1'b0;
                    st        <= RX_SECOND;
                end
                RX_SECOND: begin
                    if (toggle && !realigned) begin
                        realigned <= 1'b1;
                    end else if (tm_zero) begin
                        if (!pair_legal(pair)) begin
                            err <= 1'b1;
                            st  <= RX_IDLE;
                        end else begin
                            data <= {data[DATA_W-2:0], first_q};
                            if (left == LEN_W'(1)) begin
                                valid <= 1'b1;
                                st    <= RX_IDLE;
                            end else begin
                                left <= left - LEN_W'(1);
                                st   <= RX_FIRST;
                            end
                        end
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    assign busy = (st != RX_IDLE);

    a_r4_wait_sync: assert property (@(posedge clk) disable iff (rst)
        (st == RX_HUNT && !rise) |=> (st == RX_HUNT && !valid && !err));

    a_r5_valid_ends: assert property (@(posedge clk) disable iff (rst)
        valid |-> !busy);

    a_r7_err_pulse: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    a_r7_err_aborts: assert property (@(posedge clk) disable iff (rst)
        err |-> (!busy && !valid));

endmodule

// File: rtl/manchester_codec.sv
module manchester_codec
    import mcodec_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        half_lo,
    input  logic [7:0]        half_hi,
    input  logic [LEN_W-1:0]  code_len,
    input  logic              tx_start,
    input  logic [DATA_W-1:0] tx_data,
    output logic              line_out,
    output logic              tx_busy,
    output logic              tx_done,
    input  logic              rx_arm,
    input  logic              line_in,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              code_error,
    output logic              rx_busy
);
    logic [HALF_W-1:0] half_w;

    assign half_w = join_bytes(half_hi, half_lo);

    mc_tx #(.DATA_W(DATA_W), .LEN_W(LEN_W), .TW(HALF_W)) u_tx (
        .clk(clk), .rst(rst), .start(tx_start), .data(tx_data),
        .len(code_len), .half_w(half_w),
        .line(line_out), .busy(tx_busy), .done(tx_done)
    );

    mc_rx #(.DATA_W(DATA_W), .LEN_W(LEN_W), .TW(HALF_W)) u_rx (
        .clk(clk), .rst(rst), .arm(rx_arm), .len(code_len),
        .half_w(half_w), .line_in(line_in),
        .data(rx_data), .valid(rx_valid), .err(code_error), .busy(rx_busy)
    );

    // R3: the line is low whenever the transmitter is idle
    a_r3_idle_low: assert property (@(posedge clk) disable iff (rst)
        (!tx_busy) |-> !line_out);

endmodule

// File: tb/tb_manchester_codec.sv
`timescale 1ns/1ps
module tb_manchester_codec;
    localparam int DW = 64;
    localparam int LW = 7;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst;
    logic [7:0]    half_lo, half_hi;
    logic [LW-1:0] code_len;
    logic          tx_start, rx_arm;
    logic [DW-1:0] tx_data;
    logic          line_out, tx_busy, tx_done;
    logic          line_in;
    logic [DW-1:0] rx_data;
    logic          rx_valid, code_error, rx_busy;
    logic          lb, drv;

    assign line_in = lb ? line_out : drv;

    manchester_codec dut (
        .clk(clk), .rst(rst), .half_lo(half_lo), .half_hi(half_hi),
        .code_len(code_len), .tx_start(tx_start), .tx_data(tx_data),
        .line_out(line_out), .tx_busy(tx_busy), .tx_done(tx_done),
        .rx_arm(rx_arm), .line_in(line_in), .rx_data(rx_data),
        .rx_valid(rx_valid), .code_error(code_error), .rx_busy(rx_busy)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    int            n_valid, n_err, err_long;
    logic [DW-1:0] cap;
    logic          err_prev = 1'b0;

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<190000 cycles", cyc);
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (rx_valid) begin n_valid++; cap = rx_data; end
        if (code_error) begin n_err++; if (err_prev) err_long++; end
        err_prev = code_error;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] lowmask(int l);
        return (l >= 64) ? {64{1'b1}} : ((64'd1 << l) - 64'd1);
    endfunction

    function automatic logic exp_line(int k, int h, int l, logic [63:0] d);
        int  j;
        logic b;
        if (k <= h) return 1'b1;
        j = (k - 1 - h) / h;
        b = d[l - 1 - j / 2];
        return (j % 2 == 1) ? ~b : b;
    endfunction

    task automatic clear_mon();
        n_valid = 0; n_err = 0; err_long = 0; cap = '0;
    endtask

    task automatic set_cfg(int l, int h);
        half_lo  = h[7:0];
        half_hi  = h[15:8];
        code_len = l[LW-1:0];
    endtask

    // loopback: transmitter drives the receiver; covers R2, R3, R5
    task automatic run_loop(int l, int h, logic [63:0] d, string tag);
        int   last;
        int   first_bad;
        bit   wave_ok, done_ok;
        logic e;
        lb = 1'b1;
        set_cfg(l, h);
        tx_data = d;
        clear_mon();
        tx_start = 1'b1;
        rx_arm   = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        rx_arm   = 1'b0;
        last = h + 2 * l * h + 1;
        wave_ok = 1'b1; done_ok = 1'b1; first_bad = 0;
        for (int k = 1; k <= last; k++) begin
            if (k > 1) @(negedge clk);
            e = (k == last) ? 1'b0 : exp_line(k, h, l, d);
            if (line_out !== e && wave_ok) begin wave_ok = 1'b0; first_bad = k; end
            if (tx_done !== (k == last)) done_ok = 1'b0;
        end
        for (int k = 0; k < 2 * h + 4; k++) @(negedge clk);
        check(wave_ok, {"R2 waveform ", tag}, 64'(first_bad), 64'd0);
        check(done_ok, {"R3 done timing ", tag}, 64'(tx_done), 64'd0);
        check(n_valid == 1 && cap == (d & lowmask(l)), {"R5 decode ", tag}, cap, d & lowmask(l));
        check(!tx_busy && !rx_busy && !line_out, {"R3 idle after ", tag},
              {61'd0, tx_busy, rx_busy, line_out}, 64'd0);
    endtask

    // bench-driven line with chosen half width and an optional corrupt pair
    task automatic send_raw(int l, int h, int w, logic [63:0] d, int bad_idx, logic bad_lvl);
        logic b, f, s;
        lb  = 1'b0;
        drv = 1'b0;
        set_cfg(l, h);
        clear_mon();
        rx_arm = 1'b1;
        @(negedge clk);
        rx_arm = 1'b0;
        repeat (3) @(negedge clk);
        drv = 1'b1;
        repeat (w) @(negedge clk);
        for (int i = 0; i < l; i++) begin
            b = d[l - 1 - i];
            f = b; s = ~b;
            if (i == bad_idx) begin f = bad_lvl; s = bad_lvl; end
            drv = f;
            repeat (w) @(negedge clk);
            drv = s;
            repeat (w) @(negedge clk);
        end
        drv = 1'b0;
        repeat (3 * h + 4) @(negedge clk);
    endtask

    initial begin
        logic [63:0] d;
        int          l, h;
        rst = 1'b1; lb = 1'b1; drv = 1'b0;
        tx_start = 1'b0; rx_arm = 1'b0; tx_data = '0;
        set_cfg(8, 4);
        clear_mon();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check({line_out, tx_busy, tx_done, rx_busy, rx_valid, code_error} == 6'b0,
              "R1 reset outputs", {58'd0, line_out, tx_busy, tx_done, rx_busy, rx_valid, code_error}, 64'd0);

        // R6: shortest and longest frames
        run_loop(1, 2, 64'h1, "R6 len1 one");
        run_loop(1, 2, 64'h0, "R6 len1 zero");
        run_loop(64, 3, 64'hA5C3_0F96_7E18_D24B, "R6 len64");
        run_loop(64, 2, 64'hFFFF_FFFF_FFFF_FFFF, "R6 len64 ones");

        // R9: half width above one byte (257 cycles)
        run_loop(3, 257, 64'h5, "R9 wide timer");

        // random loopback trials
        void'($urandom(32'h1234_5678));
        for (int t = 0; t < 24; t++) begin
            l = 1 + ($urandom % 64);
            h = 2 + ($urandom % 5);
            d = {$urandom, $urandom};
            run_loop(l, h, d, "random");
        end

        // R4: armed receiver ignores a quiet line
        lb = 1'b0; drv = 1'b0;
        set_cfg(8, 4);
        clear_mon();
        rx_arm = 1'b1;
        @(negedge clk);
        rx_arm = 1'b0;
        repeat (300) @(negedge clk);
        check(n_valid == 0 && n_err == 0 && rx_busy, "R4 no sync no output",
              {62'd0, rx_busy, 1'b0} | 64'(n_valid + n_err), 64'd2);
        // the same armed receiver then takes a frame once the sync edge comes
        send_raw(8, 4, 4, 64'h9C, -1, 1'b0);
        check(n_valid == 1 && cap == 64'h9C, "R4 frame after late sync", cap, 64'h9C);

        // R8: realignment against a slow and a fast sender
        send_raw(16, 8, 9, 64'hB3E1, -1, 1'b0);
        check(n_valid == 1 && n_err == 0 && cap == 64'hB3E1, "R8 slow sender", cap, 64'hB3E1);
        send_raw(16, 8, 7, 64'h4C2D, -1, 1'b0);
        check(n_valid == 1 && n_err == 0 && cap == 64'h4C2D, "R8 fast sender", cap, 64'h4C2D);

        // R7: pair 11 in the middle, pair 00 at the front
        send_raw(8, 4, 4, 64'h35, 3, 1'b1);
        check(n_err == 1 && err_long == 0 && n_valid == 0 && !rx_busy, "R7 pair 11",
              64'(n_err * 16 + n_valid), 64'd16);
        send_raw(8, 4, 4, 64'hCA, 0, 1'b0);
        check(n_err == 1 && err_long == 0 && n_valid == 0 && !rx_busy, "R7 pair 00",
              64'(n_err * 16 + n_valid), 64'd16);

        // after an abort the receiver works again
        send_raw(5, 3, 3, 64'h16, -1, 1'b0);
        check(n_valid == 1 && cap == 64'h16, "R5 decode after abort", cap, 64'h16);

        finish_run();
    end
endmodule